// File: doc/BRIEF.md
# UART Idle Line Detector

This block sits beside a UART receiver and watches the receive line one bit at a time. The receiver hands it a strobe for each sampled bit, the value of that bit, and two framing strobes: one when a start bit is recognised and one when a stop bit is sampled. The detector counts consecutive logic-1 bits. When the run is as long as one complete frame, it has seen a whole idle character. It then raises a one-cycle pulse and sets a sticky flag that software clears later.

The run length needed follows the frame format: 8-bit data, 9-bit data, an added parity bit, or 10-bit data. Counting of idle ones can start in one of two places. In the first, it starts just after the start bit, so trailing ones in the data, the parity bit and the stop bit all count. In the second, it starts only after the stop bit. When the receiver is in idle-line wakeup, counting always starts just after the start bit, whatever the start-point setting. Once the pulse has fired, it stays quiet until the next start bit arms it again.

Top module: `uart_idle_watch`

## Requirements
- R1: The idle run length is 10 bits with cfg_nine=0, cfg_par=0 and cfg_ten=0. It is 11 bits when exactly one of cfg_nine or cfg_par is 1 and cfg_ten=0. It is 12 bits when cfg_ten=1, or when both cfg_nine and cfg_par are 1.
- R2: With the effective start point "after start bit", every 1 sampled after the start bit counts toward idle. This includes data, parity and stop bits.
- R3: With the effective start point "after stop bit", the stop_seen strobe forces the count to zero. Ones sampled inside a frame (between start_seen and stop_seen) are not counted.
- R4: The effective start point is "after stop bit" only when cfg_after_stop=1 and idle-line wakeup is not selected. Idle-line wakeup means cfg_wake_en=1 with cfg_wake_addr=0. When it is selected, counting starts after the start bit.
- R5: Any sampled 0 resets the run count to zero, and a start_seen strobe does the same.
- R6: A run of ones much longer than one frame gives exactly one pulse. The count saturates and never wraps into a second detection.
- R7: idle_pulse is high for one cycle, the cycle after the bit that completes the run. It fires at most once per idle period and is re-armed only by start_seen. After reset it stays low until a start bit has been seen.
- R8: idle_flag sets together with idle_pulse. It holds until flag_clr is asserted in a cycle with no new detection, and is 0 the cycle after that.
- R9: If a detection and flag_clr occur in the same cycle, idle_flag ends up set.
- R10: A synchronous active-high rst clears the count, disarms detection, and clears idle_pulse and idle_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | One-cycle strobe: a new receive bit was sampled |
| bit_val | input | 1 | Value of the sampled bit |
| start_seen | input | 1 | Receiver recognised a start bit (same cycle as that bit) |
| stop_seen | input | 1 | Receiver sampled the stop bit (same cycle as that bit) |
| cfg_after_stop | input | 1 | 1: idle count starts after the stop bit; 0: after the start bit |
| cfg_nine | input | 1 | 9-bit data frames |
| cfg_ten | input | 1 | 10-bit data frames |
| cfg_par | input | 1 | Parity bit present before the stop bit |
| cfg_wake_en | input | 1 | Receiver wakeup enabled |
| cfg_wake_addr | input | 1 | Wake method: 0 idle line, 1 address mark |
| flag_clr | input | 1 | Software clear strobe for idle_flag |
| idle_pulse | output | 1 | One-cycle idle-character detection |
| idle_flag | output | 1 | Sticky idle indication |

## Verification
The bench builds the block with its default parameters: a 4-bit count and a 10-bit base frame. With these defaults, every one of the 64 settings of the six configuration inputs can be swept in a single run. For each setting it sends a frame of all ones and a frame ending its data with a 0. It computes the bit index at which the pulse must appear from the run length and the effective start point. This puts the wakeup override, the stop-bit clear and the set-over-clear case at every frame length.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;

  // Number of bits in one frame: start + data + optional parity + stop.
  function automatic int unsigned frame_len(input int unsigned base_bits,
                                            input logic nine, input logic ten,
                                            input logic par);
    int unsigned n;
    if (ten)
      n = base_bits + 2;
    else
      n = base_bits + {31'd0, nine} + {31'd0, par};
    return n;
  endfunction

  // Start point is "after stop" unless idle-line wakeup overrides it.
  function automatic logic after_stop_eff(input logic after_stop,
                                          input logic wake_en,
                                          input logic wake_addr);
    return after_stop & ~(wake_en & ~wake_addr);
  endfunction

endpackage

// File: rtl/idle_gate.sv
module idle_gate (
  input  logic clk,
  input  logic rst,
  input  logic start_seen,
  input  logic stop_seen,
  input  logic cfg_after_stop,
  input  logic cfg_wake_en,
  input  logic cfg_wake_addr,
  output logic eff_after_stop,
  output logic count_ok,
  output logic clear_now
);
  import uart_idle_pkg::*;

  logic in_frame_q;

  always_ff @(posedge clk) begin
    if (rst)             in_frame_q <= 1'b0;
    else if (start_seen) in_frame_q <= 1'b1;
    else if (stop_seen)  in_frame_q <= 1'b0;
  end

  always_comb begin
    eff_after_stop = after_stop_eff(cfg_after_stop, cfg_wake_en, cfg_wake_addr);
    count_ok       = ~eff_after_stop | ~in_frame_q;
    clear_now      = start_seen | (stop_seen & eff_after_stop);
  end
endmodule

// File: rtl/idle_counter.sv
module idle_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             count_ok,
  input  logic             clear_now,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (clear_now)
      cnt_d = '0;
    else if (bit_vld) begin
      if (!bit_val)
        cnt_d = '0;
      else if (count_ok && (cnt_q < thr))
        cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/idle_event.sv
module idle_event #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_seen,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] thr,
  output logic             armed,
  output logic             fire,
  output logic             idle_pulse,
  output logic             idle_flag
);
  assign fire = armed & (cnt_d >= thr) & (cnt_q < thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      idle_pulse <= 1'b0;
      idle_flag  <= 1'b0;
    end else begin
      idle_pulse <= fire;
      if (start_seen) armed <= 1'b1;
      else if (fire)  armed <= 1'b0;
      if (fire)          idle_flag <= 1'b1;
      else if (flag_clr) idle_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_idle_watch.sv
module uart_idle_watch #(
  parameter int CNT_W     = 4,
  parameter int BASE_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_val,
  input  logic start_seen,
  input  logic stop_seen,
  input  logic cfg_after_stop,
  input  logic cfg_nine,
  input  logic cfg_ten,
  input  logic cfg_par,
  input  logic cfg_wake_en,
  input  logic cfg_wake_addr,
  input  logic flag_clr,
  output logic idle_pulse,
  output logic idle_flag
);
  import uart_idle_pkg::*;

  logic [CNT_W-1:0] idle_thr;
  logic [CNT_W-1:0] idle_cnt;
  logic [CNT_W-1:0] idle_cnt_nxt;
  logic             eff_after_stop;
  logic             count_ok;
  logic             clear_now;
  logic             armed;
  logic             fire;

  assign idle_thr = CNT_W'(frame_len(BASE_BITS, cfg_nine, cfg_ten, cfg_par));

  idle_gate u_gate (
    .clk(clk), .rst(rst),
    .start_seen(start_seen), .stop_seen(stop_seen),
    .cfg_after_stop(cfg_after_stop), .cfg_wake_en(cfg_wake_en),
    .cfg_wake_addr(cfg_wake_addr),
    .eff_after_stop(eff_after_stop), .count_ok(count_ok),
    .clear_now(clear_now)
  );

  idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .bit_vld(bit_vld), .bit_val(bit_val),
    .count_ok(count_ok), .clear_now(clear_now),
    .thr(idle_thr), .cnt_q(idle_cnt), .cnt_d(idle_cnt_nxt)
  );

  idle_event #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst(rst),
    .start_seen(start_seen), .flag_clr(flag_clr),
    .cnt_q(idle_cnt), .cnt_d(idle_cnt_nxt), .thr(idle_thr),
    .armed(armed), .fire(fire),
    .idle_pulse(idle_pulse), .idle_flag(idle_flag)
  );
endmodule

// File: rtl/uart_idle_watch_chk.sv
module uart_idle_watch_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_vld,
  input logic             bit_val,
  input logic             start_seen,
  input logic             stop_seen,
  input logic             flag_clr,
  input logic             eff_after_stop,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] thr,
  input logic             idle_pulse,
  input logic             idle_flag
);
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (cnt == '0) && !armed && !idle_pulse && !idle_flag);

  a_r5_zero_clears: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !bit_val) |=> (cnt == '0));

  a_r3_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (stop_seen && eff_after_stop) |=> (cnt == '0));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bit_val && (cnt >= thr) && !start_seen && !stop_seen)
      |=> $stable(cnt));

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    idle_pulse |=> !idle_pulse);

  a_r7_rearm_by_start: assert property (@(posedge clk) disable iff (rst)
    (!armed && !start_seen) |=> !idle_pulse);

  a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
    idle_pulse |-> idle_flag);

  a_r8_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (idle_flag && !flag_clr) |=> idle_flag);
endmodule

bind uart_idle_watch uart_idle_watch_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
  .start_seen(start_seen), .stop_seen(stop_seen), .flag_clr(flag_clr),
  .eff_after_stop(eff_after_stop), .armed(armed),
  .cnt(idle_cnt), .thr(idle_thr),
  .idle_pulse(idle_pulse), .idle_flag(idle_flag)
);

// File: tb/uart_idle_watch_tb_top.sv
module uart_idle_watch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0, bit_val = 1'b1, start_seen = 1'b0, stop_seen = 1'b0;
  logic cfg_after_stop = 1'b0, cfg_nine = 1'b0, cfg_ten = 1'b0, cfg_par = 1'b0;
  logic cfg_wake_en = 1'b0, cfg_wake_addr = 1'b0, flag_clr = 1'b0;
  logic idle_pulse, idle_flag;
  logic got;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_idle_watch dut_i (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
    .start_seen(start_seen), .stop_seen(stop_seen),
    .cfg_after_stop(cfg_after_stop), .cfg_nine(cfg_nine), .cfg_ten(cfg_ten),
    .cfg_par(cfg_par), .cfg_wake_en(cfg_wake_en), .cfg_wake_addr(cfg_wake_addr),
    .flag_clr(flag_clr), .idle_pulse(idle_pulse), .idle_flag(idle_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Present one bit for one cycle, sample the pulse one cycle later, then a gap cycle.
  task automatic send_bit(input logic v, input logic st, input logic sp,
                          input logic clr);
    bit_vld = 1'b1; bit_val = v; start_seen = st; stop_seen = sp; flag_clr = clr;
    @(posedge clk); @(negedge clk);
    got = idle_pulse;
    bit_vld = 1'b0; bit_val = 1'b1; start_seen = 1'b0; stop_seen = 1'b0;
    flag_clr = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send_frame(input int ndata, input bit last_zero, input bit par);
    send_bit(1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < ndata; k++)
      send_bit((last_zero && k == ndata-1) ? 1'b0 : 1'b1, 1'b0, 1'b0, 1'b0);
    if (par) send_bit(1'b1, 1'b0, 1'b0, 1'b0);
    send_bit(1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int c = 0; c < 64; c++) begin
      int thr, ndata, first, npulse, exp_a, exp_b;
      bit eff;
      string mreq;
      rst = 1'b1;
      cfg_after_stop = c[0]; cfg_nine = c[1]; cfg_ten = c[2];
      cfg_par = c[3]; cfg_wake_en = c[4]; cfg_wake_addr = c[5];
      // R1: run length from the frame-format inputs
      thr = cfg_ten ? 12 : ((cfg_nine && cfg_par) ? 12 : 10 + int'(cfg_nine) + int'(cfg_par));
      // R4: idle-line wakeup overrides the start point
      eff = cfg_after_stop && !(cfg_wake_en && !cfg_wake_addr);
      mreq = eff ? "R3" : (cfg_after_stop ? "R4" : "R2");
      ndata = thr - 2 - int'(cfg_par);
      repeat (2) @(negedge clk);
      rst = 1'b0;
      // R10: reset state
      check(idle_flag == 1'b0 && idle_pulse == 1'b0, "R10", "reset outputs",
            int'(idle_flag) + int'(idle_pulse), 0);

      // R7: no detection before any start bit
      npulse = 0;
      for (int i = 0; i < 14; i++) begin send_bit(1'b1, 1'b0, 1'b0, 1'b0); npulse += int'(got); end
      check(npulse == 0, "R7", "pulse before first start", npulse, 0);

      // Frame of all ones, then idle ones
      send_frame(ndata, 1'b0, cfg_par);
      exp_a = eff ? thr : 1;
      first = 0; npulse = 0;
      for (int i = 1; i <= thr + 2; i++) begin
        send_bit(1'b1, 1'b0, 1'b0, 1'b0);
        if (got) begin npulse++; if (first == 0) first = i; end
      end
      check(first == exp_a, mreq, "R1 idle index, all-ones frame", first, exp_a);
      check(npulse == 1, "R7", "pulses in idle period", npulse, 1);
      check(idle_flag == 1'b1, "R8", "flag after pulse", int'(idle_flag), 1);

      // R6: long run, no further detection
      npulse = 0;
      for (int i = 0; i < 20; i++) begin send_bit(1'b1, 1'b0, 1'b0, 1'b0); npulse += int'(got); end
      check(npulse == 0, "R6", "pulses in long run", npulse, 0);
      check(idle_flag == 1'b1, "R8", "flag holds without clear", int'(idle_flag), 1);

      // R8: software clear
      flag_clr = 1'b1; @(posedge clk); @(negedge clk); flag_clr = 1'b0;
      check(idle_flag == 1'b0, "R8", "flag after clear", int'(idle_flag), 0);

      // R5/R9: frame ending its data with 0, clear collides with detection
      send_frame(ndata, 1'b1, cfg_par);
      exp_b = eff ? thr : thr - 1 - int'(cfg_par);
      first = 0; npulse = 0;
      for (int i = 1; i <= thr + 2; i++) begin
        send_bit(1'b1, 1'b0, 1'b0, (i == exp_b) ? 1'b1 : 1'b0);
        if (got) begin npulse++; if (first == 0) first = i; end
      end
      check(first == exp_b, "R5", "idle index after zero data bit", first, exp_b);
      check(npulse == 1, "R7", "pulses after re-arm", npulse, 1);
      check(idle_flag == 1'b1, "R9", "set wins over clear", int'(idle_flag), 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule